// File: doc/BRIEF.md
# Programmable Colour Space Matrix

This block converts one three-component video pixel per clock from one colour representation to another, for example RGB to YCbCr or back. Each of its three outputs is a weighted sum of the three 10-bit inputs plus a per-output constant. The nine weights and three constants are software settings, loaded one at a time through a narrow write port.

The block uses fixed-point arithmetic and keeps full precision until the last stage. Each output is rounded to the nearest integer and then clipped to the 10-bit video range. A bypass control sends the pixel through unchanged. The bypass path has the same delay as the matrix path, so downstream logic sees one constant latency in either mode. The pipeline is three stages deep so that it can reach pixel clocks of about 150 MHz.

Top module: `csc_matrix`

## Requirements
- R1: While `rst_n` is low, `dout_vld` and all three data outputs are 0. After reset the weights form an identity mapping (`dout_yg`=green, `dout_cbb`=blue, `dout_crr`=red, each with weight 1.0) and all constants are 0, so pixels come out unchanged.
- R2: A pixel is captured on a rising edge where `din_vld` is high. Its result and a high `dout_vld` are visible after the third rising edge, counting the capture edge. This latency is the same with and without bypass, and `dout_vld` is low for every cycle that had no input pixel.
- R3: A weight word has three fields. Bit 15 is a sign that applies to the whole weight. Bits 14:10 are the integer magnitude and bits 9:0 are a fraction in 1/1024 units. The weight value is ±(integer + fraction/1024). The weight at address 3·o+i multiplies input i (0 = red/Cr, 1 = green/Y, 2 = blue/Cb) into output o (0 = Y/G, 1 = Cb/B, 2 = Cr/R).
- R4: Addresses 9, 10 and 11 hold the constants for outputs 0, 1 and 2. Each is a two's-complement value in `cfg_wdata[9:0]`. The constant actually added is four times the stored value.
- R5: Each output equals floor(Σ weight·input + 4·constant + 0.5), computed without intermediate loss, so exact halves round upward.
- R6: A result below 0 is output as 0, and a result above 1023 is output as 1023.
- R7: When `bypass` is high at the capture edge, the outputs are green, blue and red on `dout_yg`, `dout_cbb` and `dout_crr`, whatever the settings. Bypass is chosen per pixel.
- R8: A write takes effect on the edge that performs it. A pixel captured on that same edge uses the old settings, and the next pixel uses the new ones.
- R9: Writes to addresses 12 to 15 change no setting.
- R10: With the HDTV RGB-to-YCbCr set loaded (weights quantised to 1/1024, Cb and Cr constants 128), full white gives (1023, 512, 512) and black gives (0, 512, 512).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din_vld | input | 1 | Input pixel qualifier |
| din_r | input | 10 | Red / Cr input sample |
| din_g | input | 10 | Green / Y input sample |
| din_b | input | 10 | Blue / Cb input sample |
| bypass | input | 1 | Pass the pixel through unchanged |
| cfg_we | input | 1 | Setting write strobe |
| cfg_addr | input | 4 | Setting address |
| cfg_wdata | input | 16 | Setting write data |
| dout_vld | output | 1 | Output pixel qualifier |
| dout_yg | output | 10 | Y / G output |
| dout_cbb | output | 10 | Cb / B output |
| dout_crr | output | 10 | Cr / R output |

## Verification
A setting write and a pixel capture can land on the same edge. The bench provokes this by driving a weight or constant write in the same cycle as a streamed pixel, and by toggling `bypass` inside a continuous pixel stream. A behavioural model applies each write only after it has computed that cycle's pixel, and the outputs are compared with the model on every clock. Any leak of the new setting into the coinciding pixel, or a bypass flag that slips by one stage, therefore shows up as a mismatch.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int NCH = 3;

  // input channel index: 0 red/Cr, 1 green/Y, 2 blue/Cb
  // output channel index: 0 Y/G, 1 Cb/B, 2 Cr/R
  function automatic int pass_src(input int o);
    return (o == 0) ? 1 : ((o == 1) ? 2 : 0);
  endfunction
endpackage

// File: rtl/csc_cfg_regs.sv
module csc_cfg_regs
  import csc_pkg::*;
#(
  parameter int CW = 16,
  parameter int FW = 10,
  parameter int OW = 10,
  parameter int AW = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [AW-1:0]                 addr,
  input  logic [CW-1:0]                 wdata,
  output logic [NCH*NCH-1:0][CW-1:0]    coef_q,
  output logic [NCH-1:0][OW-1:0]        ofs_q
);
  localparam int NCOEF = NCH * NCH;
  localparam int NREG  = NCOEF + NCH;

  logic [NCOEF-1:0][CW-1:0] coef_d;
  logic [NCH-1:0][OW-1:0]   ofs_d;

  always_comb begin
    coef_d = coef_q;
    ofs_d  = ofs_q;
    for (int k = 0; k < NCOEF; k++) begin
      if (we && addr == AW'(k)) coef_d[k] = wdata;
    end
    for (int k = 0; k < NCH; k++) begin
      if (we && addr == AW'(NCOEF + k)) ofs_d[k] = wdata[OW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NCOEF; k++) begin
        coef_q[k] <= (k % NCH == pass_src(k / NCH)) ? CW'(2 ** FW) : '0;
      end
      ofs_q <= '0;
    end else begin
      coef_q <= coef_d;
      ofs_q  <= ofs_d;
    end
  end

  // R9: unused addresses leave every setting untouched
  a_r9_unused_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr >= AW'(NREG)) |=> ($stable(coef_q) && $stable(ofs_q)));

  // R8: a weight write is visible on the following cycle
  a_r8_coef_write: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == '0) |=> (coef_q[0] == $past(wdata)));
endmodule

// File: rtl/csc_lane.sv
module csc_lane
  import csc_pkg::*;
#(
  parameter int DW = 10,
  parameter int CW = 16,
  parameter int FW = 10,
  parameter int OW = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ld_s1,
  input  logic                      ld_s2,
  input  logic                      ld_s3,
  input  logic                      byp_s2,
  input  logic [NCH-1:0][DW-1:0]    din,
  input  logic [NCH-1:0][CW-1:0]    coef_row,
  input  logic [OW-1:0]             ofs,
  input  logic [DW-1:0]             pass,
  output logic [DW-1:0]             dout
);
  localparam int MW  = CW - 1;
  localparam int PW  = DW + CW + 2;
  localparam int ACW = PW + 2;
  localparam logic signed [ACW-1:0] RND = ACW'(2 ** (FW - 1));
  localparam logic signed [ACW-1:0] TOP = ACW'(2 ** DW - 1);

  // stage 1: decode weights and multiply
  logic signed [PW-1:0] cmag   [NCH];
  logic signed [PW-1:0] csg    [NCH];
  logic signed [PW-1:0] xin    [NCH];
  logic signed [PW-1:0] prod_d [NCH];
  logic signed [PW-1:0] prod_q [NCH];
  logic signed [OW-1:0] ofs_s1;
  logic [DW-1:0]        pass_s1;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      cmag[i]   = PW'(coef_row[i][MW-1:0]);
      csg[i]    = coef_row[i][CW-1] ? -cmag[i] : cmag[i];
      xin[i]    = PW'(din[i]);
      prod_d[i] = xin[i] * csg[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) prod_q[i] <= '0;
      ofs_s1  <= '0;
      pass_s1 <= '0;
    end else if (ld_s1) begin
      for (int i = 0; i < NCH; i++) prod_q[i] <= prod_d[i];
      ofs_s1  <= ofs;
      pass_s1 <= pass;
    end
  end

  // stage 2: sum, offset, rounding constant
  logic signed [ACW-1:0] acc_d;
  logic signed [ACW-1:0] acc_q;
  logic [DW-1:0]         pass_s2;

  always_comb begin
    acc_d = ACW'(prod_q[0]) + ACW'(prod_q[1]) + ACW'(prod_q[2])
          + (ACW'(ofs_s1) <<< (FW + 2)) + RND;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      pass_s2 <= '0;
    end else if (ld_s2) begin
      acc_q   <= acc_d;
      pass_s2 <= pass_s1;
    end
  end

  // stage 3: truncate, clip, select
  logic signed [ACW-1:0] q_s;
  logic [DW-1:0]         clip;
  logic [DW-1:0]         dout_d;

  always_comb begin
    q_s = acc_q >>> FW;
    if (acc_q[ACW-1])             clip = '0;
    else if (|q_s[ACW-1:DW])      clip = '1;
    else                          clip = q_s[DW-1:0];
    dout_d = byp_s2 ? pass_s2 : clip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dout <= '0;
    else if (ld_s3) dout <= dout_d;
  end

  // R6: negative sums clip to zero
  a_r6_clip_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_s3 && !byp_s2 && acc_q < 0) |=> (dout == '0));

  // R6: sums above full scale clip to the top code
  a_r6_clip_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_s3 && !byp_s2 && (acc_q >>> FW) > TOP) |=> (dout == '1));
endmodule

// File: rtl/csc_matrix.sv
module csc_matrix
  import csc_pkg::*;
#(
  parameter int DW = 10,
  parameter int CW = 16,
  parameter int FW = 10,
  parameter int OW = 10,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          din_vld,
  input  logic [DW-1:0] din_r,
  input  logic [DW-1:0] din_g,
  input  logic [DW-1:0] din_b,
  input  logic          bypass,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [CW-1:0] cfg_wdata,
  output logic          dout_vld,
  output logic [DW-1:0] dout_yg,
  output logic [DW-1:0] dout_cbb,
  output logic [DW-1:0] dout_crr
);
  logic [NCH*NCH-1:0][CW-1:0] coef_all;
  logic [NCH-1:0][OW-1:0]     ofs_all;
  logic [NCH-1:0][DW-1:0]     din_arr;
  logic [NCH-1:0][DW-1:0]     lane_out;
  logic                       vld_s1, vld_s2;
  logic                       byp_s1, byp_s2;

  assign din_arr = {din_b, din_g, din_r};

  csc_cfg_regs #(.CW(CW), .FW(FW), .OW(OW), .AW(AW)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .coef_q (coef_all),
    .ofs_q  (ofs_all)
  );

  // qualifier and mode pipeline
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_s1   <= 1'b0;
      vld_s2   <= 1'b0;
      dout_vld <= 1'b0;
    end else begin
      vld_s1   <= din_vld;
      vld_s2   <= vld_s1;
      dout_vld <= vld_s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byp_s1 <= 1'b0;
      byp_s2 <= 1'b0;
    end else begin
      if (din_vld) byp_s1 <= bypass;
      if (vld_s1)  byp_s2 <= byp_s1;
    end
  end

  for (genvar o = 0; o < NCH; o++) begin : g_lane
    csc_lane #(.DW(DW), .CW(CW), .FW(FW), .OW(OW)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_s1    (din_vld),
      .ld_s2    (vld_s1),
      .ld_s3    (vld_s2),
      .byp_s2   (byp_s2),
      .din      (din_arr),
      .coef_row (coef_all[o*NCH +: NCH]),
      .ofs      (ofs_all[o]),
      .pass     (din_arr[pass_src(o)]),
      .dout     (lane_out[o])
    );
  end

  assign dout_yg  = lane_out[0];
  assign dout_cbb = lane_out[1];
  assign dout_crr = lane_out[2];

  // R2: output qualifier follows the input qualifier by three edges
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    din_vld |-> ##3 dout_vld);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !din_vld |-> ##3 !dout_vld);

  // R7: bypassed pixels emerge unchanged with the same latency
  a_r7_bypass_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (din_vld && bypass) |-> ##3 (dout_yg == $past(din_g, 3) &&
                                 dout_cbb == $past(din_b, 3) &&
                                 dout_crr == $past(din_r, 3)));
endmodule

// File: tb/csc_matrix_tb.sv
module csc_matrix_tb;
  logic        clk;
  logic        rst_n;
  logic        din_vld;
  logic [9:0]  din_r, din_g, din_b;
  logic        bypass;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        dout_vld;
  logic [9:0]  dout_yg, dout_cbb, dout_crr;

  int checks;
  int fails;
  bit done;

  csc_matrix u_dut (
    .clk(clk), .rst_n(rst_n), .din_vld(din_vld),
    .din_r(din_r), .din_g(din_g), .din_b(din_b), .bypass(bypass),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .dout_vld(dout_vld), .dout_yg(dout_yg), .dout_cbb(dout_cbb), .dout_crr(dout_crr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural reference model
  int mc [9];
  int mo [3];
  int pv [3];
  int py [3];
  int pcb [3];
  int pcr [3];

  function automatic int wdec(input logic [15:0] w);
    int v;
    v = int'(w[14:10]) * 1024 + int'(w[9:0]);
    return w[15] ? -v : v;
  endfunction

  function automatic int odec(input logic [9:0] w);
    int v;
    v = int'(w);
    return (v >= 512) ? v - 1024 : v;
  endfunction

  function automatic int calc(input int o, input int r, input int g, input int b);
    int s;
    s = mc[o*3] * r + mc[o*3+1] * g + mc[o*3+2] * b + mo[o] * 4096;
    s = (s + 512) >>> 10;
    if (s < 0) s = 0;
    if (s > 1023) s = 1023;
    return s;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 9; k++) mc[k] = (k == 1 || k == 5 || k == 6) ? 1024 : 0;
      for (int k = 0; k < 3; k++) begin
        mo[k] = 0; pv[k] = 0; py[k] = 0; pcb[k] = 0; pcr[k] = 0;
      end
    end else begin
      for (int k = 2; k > 0; k--) begin
        pv[k] = pv[k-1]; py[k] = py[k-1]; pcb[k] = pcb[k-1]; pcr[k] = pcr[k-1];
      end
      pv[0] = int'(din_vld);
      if (din_vld) begin
        if (bypass) begin
          py[0] = int'(din_g); pcb[0] = int'(din_b); pcr[0] = int'(din_r);
        end else begin
          py[0]  = calc(0, int'(din_r), int'(din_g), int'(din_b));
          pcb[0] = calc(1, int'(din_r), int'(din_g), int'(din_b));
          pcr[0] = calc(2, int'(din_r), int'(din_g), int'(din_b));
        end
      end
      // R8: the write lands after this cycle's pixel was computed
      if (cfg_we && cfg_addr < 4'd9) mc[cfg_addr] = wdec(cfg_wdata);
      else if (cfg_we && cfg_addr < 4'd12) mo[cfg_addr - 4'd9] = odec(cfg_wdata[9:0]);
      // R9: addresses 12..15 are not modelled as storage
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model every cycle, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 valid", int'(dout_vld), pv[2]);
      if (pv[2] != 0) begin
        chk("R5 Y/G", int'(dout_yg), py[2]);
        chk("R5 Cb/B", int'(dout_cbb), pcb[2]);
        chk("R5 Cr/R", int'(dout_crr), pcr[2]);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pix(input int r, input int g, input int b, input bit byp);
    @(negedge clk);
    din_vld = 1'b1; din_r = 10'(r); din_g = 10'(g); din_b = 10'(b); bypass = byp;
    @(negedge clk);
    din_vld = 1'b0;
  endtask

  task automatic stream(input int n, input bit rand_byp);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      din_vld = ($urandom % 4) != 0;
      din_r = 10'($urandom); din_g = 10'($urandom); din_b = 10'($urandom);
      bypass = rand_byp ? 1'($urandom) : 1'b0;
    end
    @(negedge clk);
    din_vld = 1'b0; bypass = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic load_hdtv();
    wr(4'd0, 16'h00DA); wr(4'd1, 16'h02DC); wr(4'd2, 16'h004A);
    wr(4'd3, 16'h8078); wr(4'd4, 16'h8194); wr(4'd5, 16'h020C);
    wr(4'd6, 16'h020C); wr(4'd7, 16'h81DC); wr(4'd8, 16'h8030);
    wr(4'd9, 16'h0000); wr(4'd10, 16'h0080); wr(4'd11, 16'h0080);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0; din_vld = 1'b0; din_r = '0; din_g = '0; din_b = '0;
    bypass = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    // R1: outputs held at zero in reset
    chk("R1 vld", int'(dout_vld), 0);
    chk("R1 yg", int'(dout_yg), 0);
    chk("R1 cbb", int'(dout_cbb), 0);
    chk("R1 crr", int'(dout_crr), 0);
    rst_n = 1'b1;

    // R1: identity after reset, explicit and streamed
    pix(100, 200, 300, 1'b0);
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R1 identity yg", int'(dout_yg), 200);
    chk("R1 identity cbb", int'(dout_cbb), 300);
    chk("R1 identity crr", int'(dout_crr), 100);
    stream(40, 1'b0);
    settle();

    // R10: HDTV set, white and black
    load_hdtv();
    pix(1023, 1023, 1023, 1'b0);
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R10 white Y", int'(dout_yg), 1023);
    chk("R10 white Cb", int'(dout_cbb), 512);
    chk("R10 white Cr", int'(dout_crr), 512);
    pix(0, 0, 0, 1'b0);
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R10 black Y", int'(dout_yg), 0);
    chk("R10 black Cb", int'(dout_cbb), 512);
    chk("R10 black Cr", int'(dout_crr), 512);
    // R5 and R3: random pixels through the HDTV set
    stream(200, 1'b0);
    settle();

    // R7: bypass toggled inside a stream with a non-identity set
    stream(200, 1'b1);
    settle();

    // R8: write coincides with a streamed pixel
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      din_vld = 1'b1; din_r = 10'($urandom); din_g = 10'($urandom); din_b = 10'($urandom);
      bypass = 1'b0;
      cfg_we = 1'b1; cfg_addr = 4'($urandom % 12); cfg_wdata = 16'($urandom);
    end
    @(negedge clk);
    din_vld = 1'b0; cfg_we = 1'b0;
    settle();

    // R9: unused addresses, then check settings unchanged via pixels
    wr(4'd12, 16'hFFFF); wr(4'd13, 16'h1234); wr(4'd14, 16'h8000); wr(4'd15, 16'h7FFF);
    stream(30, 1'b0);
    settle();

    // R6: big weights force high clip, negative constants force low clip
    wr(4'd0, 16'h0A00); wr(4'd1, 16'h7FFF); wr(4'd2, 16'h0400);
    wr(4'd3, 16'h8400); wr(4'd4, 16'h0000); wr(4'd5, 16'h0000);
    wr(4'd6, 16'h0000); wr(4'd7, 16'h0200); wr(4'd8, 16'h0000);
    wr(4'd9, 16'h0000); wr(4'd10, 16'h0000); wr(4'd11, 16'h03F0);
    pix(1023, 1023, 1023, 1'b0);
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R6 high clip", int'(dout_yg), 1023);
    chk("R6 low clip", int'(dout_cbb), 0);
    // R4: 0.5*1023 - 64 = 447.5, rounds up to 448 (R5 half case)
    chk("R4 negative constant", int'(dout_crr), 448);
    stream(100, 1'b1);
    settle();

    // R3 and R4: random settings, random pixels
    for (int n = 0; n < 20; n++) begin
      wr(4'($urandom % 12), 16'($urandom));
      stream(10, 1'b1);
    end
    settle();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule